// File: doc/BRIEF.md
# Byte-Interleaved 48 kbit/s Channel Multiplexer

This block places up to eighty subscriber channels on one byte-interleaved serial line and takes them off again. A one-cycle bit-timing enable marks each line bit. In every time slot the line carries one whole byte of a single channel, together with that channel's control or indication state. That state holds steady for the full byte. Once per frame, on the frame's last bit, the frame line goes low.

A slot's position in the frame selects one of five phases and a rotation round. Each phase is programmed with one rate. A fast rate owns every slot of its phase. Slower rates take turns, slot by slot. On the transmit side an upstream source fills a one-byte holding register through a valid/ready handshake, and the block tells that source which channel the next byte must belong to. The line cannot stall, so back-pressure runs one way only. `tx_ready` falls while the holding register is full, and also in the cycle where a slot boundary takes the byte out. A slot that starts with an empty register goes out as an idle byte. The receive side follows the incoming frame line. It puts out each byte with its channel number and indication state on a single-cycle strobe. There is no ready on that side, because line bytes cannot wait.

Byte width (6 or 8) and frame length (for example 120, 480 or 640 bits) are parameters. The number of slots per frame must be a multiple of five.

Top module: `bix48_mux`

## Requirements
- R1: Each slot is BYTE_W consecutive line bits, one per `bit_en`. The byte goes out least significant bit first and arrives the same way, so the first line bit of a slot is data bit 0.
- R2: `line_frame` is low on exactly the last bit of each FRAME_BITS-bit frame and high on every other bit.
- R3: `line_ctrl` changes only on the first bit of a slot. It holds the `tx_ctrl` value of the byte sent in that slot for the whole slot.
- R4: Slot k belongs to phase p = k mod 5 and round n = k div 5. The channel is p*16 + (n AND m). The mask m comes from the phase's 2-bit field `phase_rate[2p+1:2p]`: code 0 (9600) gives m=0, code 1 (4800) gives m=1, code 2 (2400) gives m=3 and code 3 (600) gives m=15.
- R5: A byte accepted while `tx_valid && tx_ready` goes out in the next slot that starts, and it belongs to the channel `tx_need_ch` showed at acceptance. `tx_ready` is low while a byte is held and in any cycle where `bit_en` coincides with the first bit of a slot.
- R6: A slot that starts with no held byte goes out as all ones, with `line_ctrl` low.
- R7: The receiver treats the bit after any sampled low `line_rx_frame` as bit 0 of slot 0. This holds at any point in the stream, and a partly received byte is dropped.
- R8: Before the first low `line_rx_frame` has been sampled after reset, `rx_valid` stays low.
- R9: On the `bit_en` that samples a slot's last bit, the receiver raises `rx_valid` for one cycle. It presents the byte, the slot's channel (R4) and `line_rx_ind` as sampled on the slot's first bit.
- R10: During reset and until the first `bit_en`: `line_tx_data` and `line_frame` are high, `line_ctrl` is low, `tx_ready` is high and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| phase_rate | input | 10 | Rate code for each of the five phases, 2 bits each |
| tx_valid | input | 1 | Upstream byte offered |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_data | input | BYTE_W | Byte to send |
| tx_ctrl | input | 1 | Control state for that byte |
| tx_need_ch | output | 7 | Channel the next accepted byte must belong to |
| line_tx_data | output | 1 | Serial transmit data |
| line_ctrl | output | 1 | Per-slot control state |
| line_frame | output | 1 | Frame marker, low on the last bit |
| line_rx_data | input | 1 | Serial receive data |
| line_rx_ind | input | 1 | Per-slot indication state |
| line_rx_frame | input | 1 | Incoming frame marker, low on the last bit |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | BYTE_W | Received byte |
| rx_ch | output | 7 | Channel of received byte |
| rx_ind | output | 1 | Indication state of received byte |

## Verification
Two transmit events can fall on the same clock edge: an upstream offer and a slot boundary that takes the held byte out. The bench provokes this by keeping `tx_valid` high all the time with data keyed to `tx_need_ch`, so over several frames offers keep landing on boundary edges. It judges the result at the far end of a loopback. Every received byte must carry the data and control value computed for the channel that R4 assigns to its slot, and any byte that went to the wrong slot or was lost shows up as a mismatch there. On the receive side, a frame marker arrives in the middle of a byte, and the bench checks that the counter restarts and that the next full byte is reported as slot 0.

// File: rtl/bix48_pkg.sv
package bix48_pkg;
  localparam int PHASES = 5;
  localparam int PH_W   = 3;
  localparam int SUB_W  = 4;
  localparam int CH_W   = PH_W + SUB_W;

  typedef enum logic [1:0] {
    RATE_9600 = 2'd0,
    RATE_4800 = 2'd1,
    RATE_2400 = 2'd2,
    RATE_600  = 2'd3
  } rate_e;

  // how many round bits pick the sub-channel for a rate
  function automatic logic [SUB_W-1:0] sub_mask(rate_e r);
    case (r)
      RATE_9600: return 4'h0;
      RATE_4800: return 4'h1;
      RATE_2400: return 4'h3;
      default:   return 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/bix48_slot_counter.sv
module bix48_slot_counter
  import bix48_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SLOTS     = 80,
  parameter int BIT_W     = 3,
  parameter int RND_W     = 4,
  parameter bit LOOKAHEAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             resync,
  output logic [BIT_W-1:0] bit_idx,
  output logic             frame_last,
  output logic [PH_W-1:0]  sel_phase,
  output logic [RND_W-1:0] sel_round
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] slot_idx;
  logic [PH_W-1:0]   phase, nph;
  logic [RND_W-1:0]  round, nrd;
  logic              byte_last;

  assign byte_last  = (bit_idx == BIT_W'(BYTE_W - 1));
  assign frame_last = byte_last && (slot_idx == SLOT_W'(SLOTS - 1));

  // coordinates of the slot after the current one
  always_comb begin
    if (slot_idx == SLOT_W'(SLOTS - 1)) begin
      nph = '0;
      nrd = '0;
    end else if (phase == PH_W'(PHASES - 1)) begin
      nph = '0;
      nrd = round + 1'b1;
    end else begin
      nph = phase + 1'b1;
      nrd = round;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      phase    <= '0;
      round    <= '0;
    end else if (adv) begin
      if (resync || frame_last) begin
        bit_idx  <= '0;
        slot_idx <= '0;
        phase    <= '0;
        round    <= '0;
      end else if (byte_last) begin
        bit_idx  <= '0;
        slot_idx <= slot_idx + 1'b1;
        phase    <= nph;
        round    <= nrd;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  generate
    if (LOOKAHEAD) begin : g_ahead
      // slot the next byte load will serve
      assign sel_phase = (bit_idx == '0) ? phase : nph;
      assign sel_round = (bit_idx == '0) ? round : nrd;
    end else begin : g_now
      assign sel_phase = phase;
      assign sel_round = round;
    end
  endgenerate

  assert_bit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_idx) < BYTE_W);

  assert_resync_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && resync |=> bit_idx == '0 && slot_idx == '0);
endmodule

// File: rtl/bix48_slot_map.sv
module bix48_slot_map
  import bix48_pkg::*;
#(
  parameter int RND_W = 4
) (
  input  logic [2*PHASES-1:0] phase_rate,
  input  logic [PH_W-1:0]     phase,
  input  logic [RND_W-1:0]    round,
  output logic [CH_W-1:0]     ch
);
  rate_e            rt;
  logic [SUB_W-1:0] rnd_ext;

  always_comb begin
    rt = RATE_9600;
    for (int p = 0; p < PHASES; p++)
      if (phase == PH_W'(p)) rt = rate_e'(phase_rate[2*p +: 2]);
    rnd_ext = SUB_W'(round);
    ch = {phase, rnd_ext & sub_mask(rt)};
  end
endmodule

// File: rtl/bix48_tx_serializer.sv
module bix48_tx_serializer #(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              frame_last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_ctrl,
  output logic              tx_t,
  output logic              tx_c,
  output logic              tx_f
);
  logic              hold_full, hold_ctrl, load_now;
  logic [BYTE_W-1:0] hold_data, sh;

  assign load_now = bit_en && (bit_idx == '0);
  assign in_ready = !hold_full && !load_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      hold_ctrl <= 1'b0;
      sh        <= '1;
      tx_t      <= 1'b1;
      tx_c      <= 1'b0;
      tx_f      <= 1'b1;
    end else begin
      if (in_valid && in_ready) begin
        hold_full <= 1'b1;
        hold_data <= in_data;
        hold_ctrl <= in_ctrl;
      end
      if (bit_en) begin
        tx_f <= !frame_last;
        if (bit_idx == '0) begin
          if (hold_full) begin
            tx_t      <= hold_data[0];
            sh        <= {1'b1, hold_data[BYTE_W-1:1]};
            tx_c      <= hold_ctrl;
            hold_full <= 1'b0;
          end else begin
            tx_t <= 1'b1;
            sh   <= '1;
            tx_c <= 1'b0;
          end
        end else begin
          tx_t <= sh[0];
          sh   <= {1'b1, sh[BYTE_W-1:1]};
        end
      end
    end
  end

  assert_ctrl_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && bit_idx != '0 |=> $stable(tx_c));

  assert_idle_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && bit_idx == '0 && !hold_full |=> tx_t && !tx_c);

  assert_accept_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> hold_full);

  assert_frame_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && frame_last |=> !tx_f);

  assert_frame_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !tx_f |=> tx_f);
endmodule

// File: rtl/bix48_rx_deserializer.sv
module bix48_rx_deserializer
  import bix48_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              frame_last,
  input  logic [CH_W-1:0]   slot_ch,
  input  logic              rx_r,
  input  logic              rx_i,
  input  logic              rx_f,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic [CH_W-1:0]   out_ch,
  output logic              out_ind
);
  logic              locked, ind_cap;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      ind_cap   <= 1'b0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ch    <= '0;
      out_ind   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (bit_en) begin
        if (!rx_f) locked <= 1'b1;
        sh <= {rx_r, sh[BYTE_W-1:1]};
        if (bit_idx == '0) ind_cap <= rx_i;
        if (locked && bit_idx == BIT_W'(BYTE_W - 1)) begin
          out_valid <= 1'b1;
          out_data  <= {rx_r, sh[BYTE_W-1:1]};
          out_ch    <= slot_ch;
          out_ind   <= ind_cap;
        end
      end
    end
  end

  assert_quiet_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !out_valid);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // a counter wrap with the line marker high is a free-running frame end
  assert_wrap_unmarked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && frame_last && rx_f |=> bit_idx == '0);
endmodule

// File: rtl/bix48_mux.sv
module bix48_mux
  import bix48_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int FRAME_BITS = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [9:0]        phase_rate,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ctrl,
  output logic [6:0]        tx_need_ch,
  output logic              line_tx_data,
  output logic              line_ctrl,
  output logic              line_frame,
  input  logic              line_rx_data,
  input  logic              line_rx_ind,
  input  logic              line_rx_frame,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [6:0]        rx_ch,
  output logic              rx_ind
);
  localparam int SLOTS  = FRAME_BITS / BYTE_W;
  localparam int ROUNDS = SLOTS / PHASES;
  localparam int BIT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic [BIT_W-1:0] tx_bit, rx_bit;
  logic             tx_flast, rx_flast;
  logic [PH_W-1:0]  tx_ph, rx_ph;
  logic [RND_W-1:0] tx_rd, rx_rd;
  logic [CH_W-1:0]  rx_slot_ch;

  bix48_slot_counter #(.BYTE_W(BYTE_W), .SLOTS(SLOTS), .BIT_W(BIT_W),
                       .RND_W(RND_W), .LOOKAHEAD(1'b1)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .adv(bit_en), .resync(1'b0),
    .bit_idx(tx_bit), .frame_last(tx_flast),
    .sel_phase(tx_ph), .sel_round(tx_rd));

  bix48_slot_map #(.RND_W(RND_W)) u_tx_map (
    .phase_rate(phase_rate), .phase(tx_ph), .round(tx_rd), .ch(tx_need_ch));

  bix48_tx_serializer #(.BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_idx(tx_bit),
    .frame_last(tx_flast), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .in_ctrl(tx_ctrl),
    .tx_t(line_tx_data), .tx_c(line_ctrl), .tx_f(line_frame));

  bix48_slot_counter #(.BYTE_W(BYTE_W), .SLOTS(SLOTS), .BIT_W(BIT_W),
                       .RND_W(RND_W), .LOOKAHEAD(1'b0)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .adv(bit_en), .resync(!line_rx_frame),
    .bit_idx(rx_bit), .frame_last(rx_flast),
    .sel_phase(rx_ph), .sel_round(rx_rd));

  bix48_slot_map #(.RND_W(RND_W)) u_rx_map (
    .phase_rate(phase_rate), .phase(rx_ph), .round(rx_rd), .ch(rx_slot_ch));

  bix48_rx_deserializer #(.BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_idx(rx_bit),
    .frame_last(rx_flast), .slot_ch(rx_slot_ch),
    .rx_r(line_rx_data), .rx_i(line_rx_ind), .rx_f(line_rx_frame),
    .out_valid(rx_valid), .out_data(rx_data), .out_ch(rx_ch), .out_ind(rx_ind));
endmodule

// File: tb/bix48_mux_tb.sv
module bix48_mux_tb_top;
  localparam int BW    = 8;
  localparam int FB    = 640;
  localparam int SLOTS = FB / BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic [9:0]    phase_rate = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [BW-1:0] tx_data = '0;
  logic          tx_ctrl = 1'b0;
  logic [6:0]    tx_need_ch;
  logic          line_tx_data, line_ctrl, line_frame;
  logic          line_rx_data, line_rx_ind, line_rx_frame;
  logic          rx_valid;
  logic [BW-1:0] rx_data;
  logic [6:0]    rx_ch;
  logic          rx_ind;

  logic inj_mode = 1'b0, inj_r = 1'b1, inj_i = 1'b0, inj_f = 1'b1;
  assign line_rx_data  = inj_mode ? inj_r : line_tx_data;
  assign line_rx_ind   = inj_mode ? inj_i : line_ctrl;
  assign line_rx_frame = inj_mode ? inj_f : line_frame;

  bix48_mux #(.BYTE_W(BW), .FRAME_BITS(FB)) dut_i (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit gen_on = 0, prod_on = 0, mon_on = 0, done = 0;
  int mode = 0;   // 1 = data loopback, 2 = idle loopback
  int gen = 0;
  int kb = 0, rx_seen = 0, cap_cnt = 0;
  logic [BW-1:0] cap_data;
  logic [6:0]    cap_ch;
  logic          cap_ind;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ch_model(input int k, input logic [9:0] rates);
    int p, n, m;
    logic [1:0] rt;
    p  = k % 5;
    n  = k / 5;
    rt = rates[2*p +: 2];
    m  = (rt == 2'd0) ? 0 : (rt == 2'd1) ? 1 : (rt == 2'd2) ? 3 : 15;
    return p * 16 + (n & m);
  endfunction

  function automatic logic [BW-1:0] hd(input int ch, input int g);
    return BW'(ch * 37 + g * 11 + 5);
  endfunction

  function automatic logic hc(input int ch, input int g);
    return 1'(ch ^ (ch >> 4) ^ g);
  endfunction

  // bit timing: one bit every 4 clocks
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (gen_on) begin
        cnt++;
        bit_en = (cnt % 4 == 0);
      end else begin
        cnt = 0;
        bit_en = 1'b0;
      end
    end
  end

  // upstream source: always offering the byte for the channel asked for
  initial forever begin
    @(negedge clk);
    tx_valid = prod_on;
    tx_data  = hd(int'(tx_need_ch), gen);
    tx_ctrl  = hc(int'(tx_need_ch), gen);
  end

  // line and receive monitor
  initial begin
    int pos;
    bit pos_ok;
    logic prev_c;
    pos = 0; pos_ok = 0; prev_c = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
        pos = 0; pos_ok = 0; prev_c = 1'b0;
      end else begin
        if (mon_on && bit_en) begin
          if (pos_ok) begin
            check(line_frame == (pos != FB - 1), "R2", int'(line_frame), int'(pos != FB - 1));
            if (pos % BW != 0)
              check(line_ctrl == prev_c, "R3", int'(line_ctrl), int'(prev_c));
          end
          if (mode == 2)
            check(line_tx_data && !line_ctrl, "R6", int'({line_tx_data, line_ctrl}), 2);
          prev_c = line_ctrl;
          if (!line_frame) begin pos_ok = 1; pos = 0; end
          else pos = (pos + 1) % FB;
        end
        if (rx_valid) begin
          cap_cnt++;
          cap_data = rx_data;
          cap_ch   = rx_ch;
          cap_ind  = rx_ind;
          if (mon_on) begin
            rx_seen++;
            check(int'(rx_ch) == ch_model(kb, phase_rate), "R4", int'(rx_ch), ch_model(kb, phase_rate));
            if (mode == 1) begin
              check(rx_data == hd(int'(rx_ch), gen), "R5 R1", int'(rx_data), int'(hd(int'(rx_ch), gen)));
              check(rx_ind == hc(int'(rx_ch), gen), "R3 R9", int'(rx_ind), int'(hc(int'(rx_ch), gen)));
            end else if (mode == 2) begin
              check(rx_data == '1 && !rx_ind, "R6", int'({rx_data, rx_ind}), int'({{BW{1'b1}}, 1'b0}));
            end
            kb = (kb + 1) % SLOTS;
          end
        end
      end
    end
  end

  task automatic do_reset(input logic [9:0] rates);
    gen_on = 0; prod_on = 0; mon_on = 0; inj_mode = 0;
    rst_n = 1'b0;
    phase_rate = rates;
    repeat (6) @(posedge clk);
    kb = 0; rx_seen = 0; cap_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();   // R10
    do_reset(10'b00_11_10_01_00);
    @(negedge clk);
    check(line_tx_data == 1'b1, "R10 data", int'(line_tx_data), 1);
    check(line_frame == 1'b1, "R10 frame", int'(line_frame), 1);
    check(line_ctrl == 1'b0, "R10 ctrl", int'(line_ctrl), 0);
    check(tx_ready == 1'b1, "R10 ready", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R10 valid", int'(rx_valid), 0);
  endtask

  // R1 R2 R3 R4 R5 R9: full loopback with boundary-coincident offers
  task automatic t_loopback(input logic [9:0] rates, input int g);
    do_reset(rates);
    gen = g; mode = 1;
    prod_on = 1; mon_on = 1; gen_on = 1;
    repeat (4 * FB * 4) @(posedge clk);
    #1;
    check(rx_seen >= 3 * SLOTS - 1 && rx_seen <= 3 * SLOTS, "R9 count", rx_seen, 3 * SLOTS);
    mon_on = 0; prod_on = 0;
  endtask

  task automatic t_underrun();       // R6
    do_reset(10'b01_00_11_10_00);
    mode = 2;
    mon_on = 1; gen_on = 1;
    repeat (2 * FB * 4 + 40) @(posedge clk);
    #1;
    check(rx_seen >= SLOTS - 1, "R6 count", rx_seen, SLOTS);
    mon_on = 0;
  endtask

  task automatic send_bit(input logic r, input logic i, input logic f);
    inj_r = r; inj_i = i; inj_f = f;
    do @(posedge clk); while (!bit_en);
    #2;
  endtask

  task automatic send_byte(input logic [BW-1:0] b, input logic ind);
    for (int j = 0; j < BW; j++) send_bit(b[j], ind, 1'b1);
  endtask

  task automatic t_inject();         // R7 R8 R9 R1
    do_reset(10'b00_11_10_01_00);
    mode = 0;
    inj_mode = 1; gen_on = 1;
    do @(posedge clk); while (!bit_en);
    #2;
    for (int j = 0; j < 21; j++) send_bit(1'(j % 3 == 0), 1'b1, 1'b1);
    check(cap_cnt == 0, "R8", cap_cnt, 0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_byte(8'hA5, 1'b1);
    check(cap_cnt == 1, "R9 strobe", cap_cnt, 1);
    check(cap_data == 8'hA5, "R1 R9 data", int'(cap_data), 'hA5);
    check(cap_ch == 7'd0, "R9 ch", int'(cap_ch), 0);
    check(cap_ind == 1'b1, "R9 ind", int'(cap_ind), 1);
    // marker in the middle of the next byte: partial byte dropped
    for (int j = 0; j < 3; j++) send_bit(1'b0, 1'b1, 1'b1);
    send_bit(1'b1, 1'b1, 1'b0);
    check(cap_cnt == 1, "R7 drop", cap_cnt, 1);
    send_byte(8'h3C, 1'b0);
    check(cap_cnt == 2, "R7 strobe", cap_cnt, 2);
    check(cap_data == 8'h3C && cap_ch == 7'd0, "R7 slot0", int'({cap_ch, cap_data}), 'h3C);
    check(cap_ind == 1'b0, "R9 ind low", int'(cap_ind), 0);
    send_byte(8'h81, 1'b1);
    check(cap_data == 8'h81, "R1 data", int'(cap_data), 'h81);
    check(int'(cap_ch) == ch_model(1, phase_rate), "R4 slot1", int'(cap_ch), ch_model(1, phase_rate));
    inj_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_loopback(10'b00_11_10_01_00, 3);
    t_loopback(10'b01_00_11_01_10, 6);
    t_underrun();
    t_inject();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule